// File: doc/BRIEF.md
# Debug-Aware Deep Sleep Controller

This block picks the low-power state a microcontroller enters when software pulses a deep sleep request. It has three sleep depths. The shallow emulated level keeps the core domain powered and its state intact. The middle level removes core power but leaves the low-frequency RC oscillator running. The deepest level also stops that oscillator. A configuration input chooses between the two true-sleep levels. Two debug flags override that choice. A connected debugger limits sleep to the emulated level, and an active system-access request refuses sleep altogether.

The debug flags live inside the block. Only a power-on reset or an explicit debugger write changes them, and a system reset leaves them alone. A rising flag wakes the chip from any sleep level, and so do external wake events. Timer and watchdog events also wake the chip, except in the deepest level without a crystal. Each wake from a true sleep passes through a settle phase of a fixed number of cycles. The RC oscillator and the core power are back on during that phase.

The debugger memory access uses a valid/ready pair. The debugger raises `dbg_acc_valid` and must hold it until it sees `dbg_acc_ready` high in the same cycle. Ready is low in both true-sleep levels and during settling, which holds the debugger off. A valid access that arrives during any sleep level is itself a wake source.

Top module: `dsleep_ctrl`

## Requirements
- R1: With both debug flags clear and `rc_off_sel`=0, a request pulse in RUN enters the RC-on deep level (`sleep_state`=2) two sample points later. In that level `rc_osc_en`=1 and `core_pwr_en`=0.
- R2: With `rc_off_sel`=1 and both flags clear, a request enters the RC-off deep level (`sleep_state`=3), where `rc_osc_en`=0 and `core_pwr_en`=0.
- R3: In the RC-off level with `xtal_present`=0, `timer_wake_en` is 0, and pulses on `timer_wake` or `wdog_wake` leave the state unchanged. With `xtal_present`=1 a timer pulse wakes the chip. `ext_wake` wakes it in every case.
- R4: A wake from either deep level moves to SETTLE (`sleep_state`=4), with `rc_osc_en`=1 and `core_pwr_en`=1. The block stays there for exactly SETTLE_CYCLES cycles and then returns to RUN (`sleep_state`=0).
- R5: While `dbg_conn_flag`=1, a request enters only the emulated level (`sleep_state`=1), where `core_pwr_en` stays 1. A wake there returns to RUN on the next edge, with no settle phase.
- R6: While `sys_acc_flag`=1 in RUN, a request is refused and the state stays RUN.
- R7: A debugger write that raises either flag while in a deep level wakes the chip into SETTLE.
- R8: `dbg_acc_ready` is 0 in both deep levels and in SETTLE, and 1 in RUN and in the emulated level. `dbg_acc_valid` during sleep is a wake source.
- R9: The flags follow `dbg_wr_conn`/`dbg_wr_sys` when `dbg_wr_en`=1. They are cleared by `por_n` low, and they keep their value through `rst_n` low and through sleep entry.
- R10: A request outside RUN is ignored. In SETTLE it does not lengthen the phase or start a new sleep.
- R11: After reset the block is in RUN with `rc_osc_en`, `core_pwr_en`, `timer_wake_en` and `dbg_acc_ready` all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; resets everything including the debug flags |
| rst_n | input | 1 | System reset, active low; resets the state machine only |
| sleep_req | input | 1 | Single-cycle deep sleep request |
| rc_off_sel | input | 1 | 1 selects the RC-off deep level |
| xtal_present | input | 1 | Low-frequency crystal is in use |
| timer_wake | input | 1 | Sleep timer wake event |
| wdog_wake | input | 1 | Watchdog wake event |
| ext_wake | input | 1 | Non-timer wake event |
| dbg_wr_en | input | 1 | Debugger write strobe for the flags |
| dbg_wr_conn | input | 1 | New debug-connected value |
| dbg_wr_sys | input | 1 | New system-access value |
| dbg_acc_valid | input | 1 | Debugger memory access request |
| dbg_acc_ready | output | 1 | Access may proceed this cycle |
| dbg_conn_flag | output | 1 | Debug-connected flag |
| sys_acc_flag | output | 1 | System-access flag |
| sleep_state | output | 3 | 0 RUN, 1 emulated, 2 RC-on deep, 3 RC-off deep, 4 SETTLE |
| rc_osc_en | output | 1 | RC oscillator enable |
| core_pwr_en | output | 1 | Core power domain enable |
| timer_wake_en | output | 1 | Timer and watchdog may wake the chip |

## Verification
A wrong next-state choice shows on `sleep_state` and on the power and oscillator enables two sample points after the request or wake event. One example is taking a true sleep while a flag is set. Another is a timer wake that gets through the crystal-less RC-off level. A fault in the settle counter shows only at the end of the phase, SETTLE_CYCLES cycles later. It appears as the early or late return of `dbg_acc_ready` and of `sleep_state`=0. Flag corruption from a system reset is visible on the flag outputs one cycle after the reset is released.

// File: rtl/dsleep_pkg.sv
package dsleep_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_EMU     = 3'd1,
    ST_DEEP_RC = 3'd2,
    ST_DEEP_NO = 3'd3,
    ST_SETTLE  = 3'd4
  } dsl_state_e;
endpackage

// File: rtl/dsleep_dbg_flags.sv
module dsleep_dbg_flags (
  input  logic clk,
  input  logic por_n,
  input  logic wr_en,
  input  logic wr_conn,
  input  logic wr_sys,
  output logic conn_q,
  output logic sys_q,
  output logic conn_rise,
  output logic sys_rise
);
  // Only power-on reset clears these; system reset is not wired here.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      conn_q <= 1'b0;
      sys_q  <= 1'b0;
    end else if (wr_en) begin
      conn_q <= wr_conn;
      sys_q  <= wr_sys;
    end
  end

  assign conn_rise = wr_en & wr_conn & ~conn_q;
  assign sys_rise  = wr_en & wr_sys  & ~sys_q;

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable({conn_q, sys_q}));
endmodule

// File: rtl/dsleep_wake_qual.sv
module dsleep_wake_qual
  import dsleep_pkg::*;
(
  input  dsl_state_e state,
  input  logic       xtal_present,
  input  logic       timer_wake,
  input  logic       wdog_wake,
  input  logic       ext_wake,
  input  logic       conn_rise,
  input  logic       sys_rise,
  input  logic       acc_valid,
  output logic       timer_en,
  output logic       wake
);
  always_comb begin
    timer_en = !((state == ST_DEEP_NO) && !xtal_present);
    wake = ext_wake | (timer_en & (timer_wake | wdog_wake))
         | conn_rise | sys_rise | acc_valid;
  end
endmodule

// File: rtl/dsleep_settle.sv
module dsleep_settle #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!active || done) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign done = active && (cnt_q == LAST);
endmodule

// File: rtl/dsleep_fsm.sv
module dsleep_fsm
  import dsleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       rc_off_sel,
  input  logic       dbg_conn,
  input  logic       sys_acc,
  input  logic       wake,
  input  logic       settle_done,
  output dsl_state_e state_q
);
  dsl_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req && !sys_acc) begin
          if (dbg_conn)        state_d = ST_EMU;
          else if (rc_off_sel) state_d = ST_DEEP_NO;
          else                 state_d = ST_DEEP_RC;
        end
      end
      ST_EMU:                 if (wake) state_d = ST_RUN;
      ST_DEEP_RC, ST_DEEP_NO: if (wake) state_d = ST_SETTLE;
      ST_SETTLE:              if (settle_done) state_d = ST_RUN;
      default:                state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req && sys_acc) |=> state_q == ST_RUN);

  p_shallow_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req && dbg_conn && !sys_acc) |=> state_q == ST_EMU);

  p_settle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && !settle_done) |=> state_q == ST_SETTLE);
endmodule

// File: rtl/dsleep_ctrl.sv
module dsleep_ctrl
  import dsleep_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       rc_off_sel,
  input  logic       xtal_present,
  input  logic       timer_wake,
  input  logic       wdog_wake,
  input  logic       ext_wake,
  input  logic       dbg_wr_en,
  input  logic       dbg_wr_conn,
  input  logic       dbg_wr_sys,
  input  logic       dbg_acc_valid,
  output logic       dbg_acc_ready,
  output logic       dbg_conn_flag,
  output logic       sys_acc_flag,
  output logic [2:0] sleep_state,
  output logic       rc_osc_en,
  output logic       core_pwr_en,
  output logic       timer_wake_en
);
  logic       sys_rst_n;
  logic       conn_rise, sys_rise;
  logic       wake, settle_done;
  dsl_state_e state;

  assign sys_rst_n = rst_n & por_n;

  dsleep_dbg_flags u_flags (
    .clk(clk), .por_n(por_n), .wr_en(dbg_wr_en), .wr_conn(dbg_wr_conn),
    .wr_sys(dbg_wr_sys), .conn_q(dbg_conn_flag), .sys_q(sys_acc_flag),
    .conn_rise(conn_rise), .sys_rise(sys_rise)
  );

  dsleep_wake_qual u_wake (
    .state(state), .xtal_present(xtal_present), .timer_wake(timer_wake),
    .wdog_wake(wdog_wake), .ext_wake(ext_wake), .conn_rise(conn_rise),
    .sys_rise(sys_rise), .acc_valid(dbg_acc_valid),
    .timer_en(timer_wake_en), .wake(wake)
  );

  dsleep_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(sys_rst_n), .active(state == ST_SETTLE), .done(settle_done)
  );

  dsleep_fsm u_fsm (
    .clk(clk), .rst_n(sys_rst_n), .sleep_req(sleep_req), .rc_off_sel(rc_off_sel),
    .dbg_conn(dbg_conn_flag), .sys_acc(sys_acc_flag), .wake(wake),
    .settle_done(settle_done), .state_q(state)
  );

  assign sleep_state   = state;
  assign rc_osc_en     = (state != ST_DEEP_NO);
  assign core_pwr_en   = !((state == ST_DEEP_RC) || (state == ST_DEEP_NO));
  assign dbg_acc_ready = (state == ST_RUN) || (state == ST_EMU);

  // R3: timer events must not leave the crystal-less RC-off level
  p_timer_gate_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (state == ST_DEEP_NO && !xtal_present && !ext_wake && !dbg_acc_valid
     && !conn_rise && !sys_rise) |=> state == ST_DEEP_NO);

  // R7: a raised flag during true sleep starts the settle phase
  p_flag_wake_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ((state == ST_DEEP_RC || state == ST_DEEP_NO) && (conn_rise || sys_rise))
    |=> state == ST_SETTLE);
endmodule

// File: tb/dsleep_ctrl_tb.sv
module dsleep_ctrl_tb;
  localparam int SETTLE = 16;
  localparam logic [2:0] S_RUN = 3'd0, S_EMU = 3'd1, S_DRC = 3'd2, S_DNO = 3'd3, S_SET = 3'd4;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, rc_off_sel = 0, xtal_present = 0;
  logic timer_wake = 0, wdog_wake = 0, ext_wake = 0;
  logic dbg_wr_en = 0, dbg_wr_conn = 0, dbg_wr_sys = 0, dbg_acc_valid = 0;
  logic dbg_acc_ready, dbg_conn_flag, sys_acc_flag, rc_osc_en, core_pwr_en, timer_wake_en;
  logic [2:0] sleep_state;

  always #4 clk = ~clk;

  dsleep_ctrl #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sleep_req(sleep_req),
    .rc_off_sel(rc_off_sel), .xtal_present(xtal_present), .timer_wake(timer_wake),
    .wdog_wake(wdog_wake), .ext_wake(ext_wake), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_conn(dbg_wr_conn), .dbg_wr_sys(dbg_wr_sys), .dbg_acc_valid(dbg_acc_valid),
    .dbg_acc_ready(dbg_acc_ready), .dbg_conn_flag(dbg_conn_flag),
    .sys_acc_flag(sys_acc_flag), .sleep_state(sleep_state), .rc_osc_en(rc_osc_en),
    .core_pwr_en(core_pwr_en), .timer_wake_en(timer_wake_en)
  );

  typedef struct {
    int         cyc;
    logic [8:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, tests = 0, fails = 0;
  logic m_conn = 0, m_sys = 0;

  // Expected port image for a given state, built from the requirements
  task automatic push(input int d, input logic [2:0] st, input string tag);
    exp_t e;
    logic rc, core, twe, rdy;
    rc   = (st != S_DNO);
    core = !(st == S_DRC || st == S_DNO);
    twe  = !(st == S_DNO && !xtal_present);
    rdy  = (st == S_RUN || st == S_EMU);
    e.cyc = cyc + d;
    e.val = {st, rc, core, twe, rdy, m_conn, m_sys};
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares outputs at the falling edge
  always @(negedge clk) begin
    logic [8:0] act;
    cyc++;
    act = {sleep_state, rc_osc_en, core_pwr_en, timer_wake_en, dbg_acc_ready,
           dbg_conn_flag, sys_acc_flag};
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        tests++;
        if (act !== q[i].val) begin
          fails++;
          $display("FAIL %s cycle %0d: got %b expected %b", q[i].tag, cyc, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic dwrite(input logic c, input logic s);
    dbg_wr_en = 1; dbg_wr_conn = c; dbg_wr_sys = s;
    tick(1);
    dbg_wr_en = 0;
    m_conn = c; m_sys = s;
  endtask

  task automatic req_pulse();
    sleep_req = 1; tick(1); sleep_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    por_n = 1; rst_n = 1;
    tick(2);
    push(1, S_RUN, "R11 reset state");
    tick(2);

    // R1 default level
    push(2, S_DRC, "R1 rc-on deep"); req_pulse(); tick(2);
    push(1, S_DRC, "R1 holds");
    // R4 timer wake and settle length
    timer_wake = 1;
    push(2, S_SET, "R4 settle start"); push(17, S_SET, "R4 settle last");
    push(18, S_RUN, "R4 back to run");
    tick(1); timer_wake = 0; tick(20);

    // R2 / R3 rc-off without crystal
    rc_off_sel = 1;
    push(2, S_DNO, "R2 rc-off deep"); req_pulse(); tick(2);
    timer_wake = 1; push(2, S_DNO, "R3 timer ignored"); tick(1); timer_wake = 0; tick(2);
    wdog_wake = 1;  push(2, S_DNO, "R3 wdog ignored");  tick(1); wdog_wake = 0; tick(2);
    ext_wake = 1;
    push(2, S_SET, "R3 ext wakes"); push(18, S_RUN, "R10 settle not extended");
    tick(1); ext_wake = 0; tick(4);
    push(2, S_SET, "R10 request ignored in settle"); req_pulse(); tick(17);
    push(1, S_RUN, "R10 stays run"); tick(2);

    // R3 rc-off with crystal
    xtal_present = 1;
    push(2, S_DNO, "R3 rc-off with xtal"); req_pulse(); tick(2);
    timer_wake = 1;
    push(2, S_SET, "R3 timer wakes with xtal"); push(18, S_RUN, "R4 run after xtal wake");
    tick(1); timer_wake = 0; tick(20);
    xtal_present = 0; rc_off_sel = 0;

    // R7 connect flag wakes from rc-on deep
    push(2, S_DRC, "R1 rc-on again"); req_pulse(); tick(2);
    dwrite(1, 0);
    push(1, S_SET, "R7 conn rise wakes"); push(17, S_RUN, "R7 run after settle");
    tick(19);

    // R5 emulated level
    push(2, S_EMU, "R5 emulated only"); req_pulse(); tick(2);
    push(1, S_EMU, "R5 core kept on");
    ext_wake = 1; push(2, S_RUN, "R5 direct return"); tick(1); ext_wake = 0; tick(3);

    // R6 system access refuses sleep
    dwrite(0, 1);
    push(2, S_RUN, "R6 refused"); push(3, S_RUN, "R6 still run"); req_pulse(); tick(4);

    // R7 sys flag rise from rc-off deep
    dwrite(0, 0);
    rc_off_sel = 1;
    push(2, S_DNO, "R2 rc-off again"); req_pulse(); tick(2);
    dwrite(0, 1);
    push(1, S_SET, "R7 sys rise wakes"); push(17, S_RUN, "R7 run after sys wake");
    tick(19);
    dwrite(0, 0);
    rc_off_sel = 0;

    // R8 access hold-off and wake
    push(2, S_DRC, "R8 ready low in deep"); req_pulse(); tick(2);
    dbg_acc_valid = 1;
    push(2, S_SET, "R8 access wakes"); push(17, S_SET, "R8 still held");
    push(18, S_RUN, "R8 ready after settle");
    tick(20); dbg_acc_valid = 0;

    // R9 flags survive system reset, cleared by power-on reset
    dwrite(1, 1);
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    push(1, S_RUN, "R9 flags kept over rst_n"); tick(2);
    por_n = 0; tick(2); por_n = 1; m_conn = 0; m_sys = 0; tick(1);
    push(1, S_RUN, "R9 flags cleared by por_n"); tick(3);

    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule